// File: doc/BRIEF.md
# Holdover Tuning Word Averager

This block sits after the loop filter of a frequency synthesis loop. It samples the loop's frequency tuning word on a strobe whose rate is the system clock divided by 2^D. It averages those samples over tumbling windows of 2^N samples. While the loop tracks, the output follows the sampled tuning word.

When holdover starts, the output freezes. It holds either the word sampled last or the average of the most recent complete window, as a mode input selects. The output stays frozen until holdover ends. After holdover ends, the window restarts, so the average is only trusted again once a fresh window has filled.

Holdover is decided by a small controller. A manual override has the highest priority. The external holdover pin comes next. The automatic request comes last, gated separately for entry and for recovery. A second registered selector picks reference A or B from a manual bit, from the automatic choice or from the select pin.

Top module: `tw_holdover_avg`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tw_out`, `holdover`, `avg_valid` and `ref_sel_b` become 0. The strobe counter and the window restart at zero.
- R2: A free-running counter starts at 0 after reset and advances once per clock. A sample strobe occurs in a cycle whose counter has its low `div_exp` bits all ones. When `div_exp` is 0, every cycle has a strobe. On a strobe while tracking, `tw_out` takes `tw_in` at that edge.
- R3: Samples taken while tracking fill windows of 2^`win_exp` samples. When a window completes, the averaged word becomes floor(sum/2^`win_exp`) and `avg_valid` goes to 1 at that same edge. The next window then starts empty.
- R4: On holdover entry with `avg_mode`=1 and `avg_valid`=1, `tw_out` takes the average of the latest complete window.
- R5: On holdover entry with `avg_mode`=0, `tw_out` keeps the word sampled last.
- R6: On holdover entry with `avg_mode`=1 but `avg_valid`=0, `tw_out` keeps the word sampled last.
- R7: While `holdover` is 1, `tw_out` stays constant and no sample enters the window, whatever `tw_in` does. The entry cycle also takes no sample.
- R8: At the edge where holdover ends, `avg_valid` drops to 0 and the window empties. `tw_out` then follows `tw_in` again from the next strobe.
- R9: Without override and with the pin low, holdover is entered only if `auto_req`=1 and `auto_hold_en`=1. It is left only if `auto_req`=0 and `auto_recover_en`=1.
- R10: With `hold_ovr`=1, `holdover` at the next edge equals `hold_manual`, regardless of `hold_pin` and `auto_req`.
- R11: With `hold_ovr`=0, `hold_pin`=1 forces holdover at the next edge.
- R12: `ref_sel_b` (0 = reference A, 1 = reference B) is registered. It takes `ref_manual_b` if `ref_ovr`=1, else `ref_auto_b` if `auto_sel_en`=1, else `ref_pin_b`.
- R13: A window of 2^15 all-ones words averages to all ones without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tw_in | input | TW_W | Live tuning word from the loop |
| win_exp | input | EXP_W | Window size exponent N (2^N samples) |
| div_exp | input | EXP_W | Strobe divider exponent D (clock/2^D) |
| avg_mode | input | 1 | 1 = hold the average, 0 = hold the last word |
| auto_req | input | 1 | Automatic holdover request from fault logic |
| auto_hold_en | input | 1 | Permits automatic entry into holdover |
| auto_recover_en | input | 1 | Permits automatic exit from holdover |
| hold_pin | input | 1 | External holdover pin |
| hold_ovr | input | 1 | Manual holdover override enable |
| hold_manual | input | 1 | Manual holdover state when overridden |
| ref_auto_b | input | 1 | Automatic reference choice (1 = B) |
| auto_sel_en | input | 1 | Permits automatic reference switching |
| ref_pin_b | input | 1 | External reference select pin (1 = B) |
| ref_ovr | input | 1 | Manual reference override enable |
| ref_manual_b | input | 1 | Manual reference choice (1 = B) |
| tw_out | output | TW_W | Tuning word delivered to the synthesizer |
| holdover | output | 1 | 1 while in holdover |
| avg_valid | output | 1 | A complete window average is available |
| ref_sel_b | output | 1 | Selected reference (1 = B) |

## Verification
A stuck or miscounted window counter shows up at `avg_valid`. That flag rises on a strobe other than the 2^N-th one after reset or after a holdover exit, within one window. A wrong accumulator or shift stays hidden until the next holdover entry in averaged mode, when `tw_out` takes a wrong word on that very edge. A wrong priority in the hold controller shows at `holdover` one edge after the offending input pattern. A leak of samples during holdover moves `tw_out` on the first strobe inside holdover.

// File: rtl/tw_hold_pkg.sv
// Shared types and helpers for the holdover tuning word averager.
// Assumes exponents never exceed 31.
package tw_hold_pkg;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_e;

    // Low-order mask of e ones, for power-of-two counters and windows.
    function automatic logic [31:0] ones_mask(input int unsigned e);
        return (32'd1 << e) - 32'd1;
    endfunction

endpackage

// File: rtl/tw_strobe_gen.sv
// Sample strobe generator: free-running counter from reset; strobe when the
// low div_exp counter bits are all ones, so the rate is clk / 2^div_exp.
// Assumes div_exp <= 2^EXP_W - 1.
module tw_strobe_gen
    import tw_hold_pkg::*;
#(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] div_exp,
    output logic             strobe
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sel_mask;

    // Free-running phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Mask of the bits that must all be ones for a strobe.
    always_comb begin
        sel_mask = CNT_W'(ones_mask(32'(div_exp)));
        strobe   = ((cnt_q & sel_mask) == sel_mask);
    end

endmodule

// File: rtl/tw_hold_ctrl.sv
// Holdover controller and reference selector.
// Holdover priority: manual override, then pin, then gated automatic request.
// Reference priority: manual override, then automatic choice, then pin.
module tw_hold_ctrl
    import tw_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_req,
    input  logic auto_hold_en,
    input  logic auto_recover_en,
    input  logic hold_pin,
    input  logic hold_ovr,
    input  logic hold_manual,
    input  logic ref_auto_b,
    input  logic auto_sel_en,
    input  logic ref_pin_b,
    input  logic ref_ovr,
    input  logic ref_manual_b,
    output logic hold_q,
    output logic hold_d,
    output logic ref_sel_b
);
    hold_state_e st_q, st_d;

    // Next holdover state by priority.
    always_comb begin
        st_d = st_q;
        if (hold_ovr) begin
            st_d = hold_manual ? ST_HOLD : ST_TRACK;
        end else if (hold_pin) begin
            st_d = ST_HOLD;
        end else begin
            case (st_q)
                ST_TRACK: if (auto_req && auto_hold_en)     st_d = ST_HOLD;
                ST_HOLD:  if (!auto_req && auto_recover_en) st_d = ST_TRACK;
                default:  st_d = ST_TRACK;
            endcase
        end
    end

    // Holdover state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_TRACK;
        else        st_q <= st_d;
    end

    // Registered reference selection.
    always_ff @(posedge clk) begin
        if (!rst_n)           ref_sel_b <= 1'b0;
        else if (ref_ovr)     ref_sel_b <= ref_manual_b;
        else if (auto_sel_en) ref_sel_b <= ref_auto_b;
        else                  ref_sel_b <= ref_pin_b;
    end

    assign hold_q = (st_q == ST_HOLD);
    assign hold_d = (st_d == ST_HOLD);

    AST_OVR_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ovr |=> (hold_q == $past(hold_manual)));  // R10
    AST_PIN_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ovr && hold_pin) |=> hold_q);  // R11
    AST_NO_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q && !hold_ovr && !hold_pin && !auto_hold_en) |=> !hold_q);  // R9
    AST_NO_AUTO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !hold_ovr && !auto_recover_en) |=> hold_q);  // R9
    AST_REF_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ovr |=> (ref_sel_b == $past(ref_manual_b)));  // R12

endmodule

// File: rtl/tw_window_avg.sv
// Tumbling-window averager: sums 2^win_exp samples, then publishes
// sum >> win_exp and marks it valid. The restart input empties the window
// and clears validity. The accumulator carries 2^EXP_W-1 guard bits, so the
// largest window cannot overflow.
module tw_window_avg
    import tw_hold_pkg::*;
#(
    parameter int TW_W  = 24,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             restart,
    input  logic [TW_W-1:0]  tw_in,
    input  logic [EXP_W-1:0] win_exp,
    output logic [TW_W-1:0]  avg_word,
    output logic             avg_valid
);
    localparam int GUARD = (1 << EXP_W) - 1;
    localparam int ACC_W = TW_W + GUARD;

    logic [ACC_W-1:0] acc_q;
    logic [GUARD-1:0] cnt_q;
    logic [ACC_W:0]   sum_ext;
    logic             win_last;

    // Running sum with the new sample and end-of-window detection.
    always_comb begin
        sum_ext  = {1'b0, acc_q} + {{(ACC_W + 1 - TW_W){1'b0}}, tw_in};
        win_last = (cnt_q == GUARD'(ones_mask(32'(win_exp))));
    end

    // Accumulate, close windows and publish averages.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            avg_valid <= 1'b0;
            if (!rst_n) avg_word <= '0;
        end else if (sample_en) begin
            if (win_last) begin
                acc_q     <= '0;
                cnt_q     <= '0;
                avg_word  <= TW_W'(sum_ext[ACC_W-1:0] >> win_exp);
                avg_valid <= 1'b1;
            end else begin
                acc_q <= sum_ext[ACC_W-1:0];
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> !sum_ext[ACC_W]);  // R13
    AST_VALID_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avg_valid) |-> $past(sample_en));  // R3
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !avg_valid);  // R8

endmodule

// File: rtl/tw_holdover_avg.sv
// Top: holdover tuning word averager. Samples the loop tuning word on a
// divided strobe, averages over 2^N windows, and freezes the output on
// holdover entry to the last word or to the window average.
// Assumes configuration inputs are quasi-static within a window.
module tw_holdover_avg
    import tw_hold_pkg::*;
#(
    parameter int TW_W  = 24,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW_W-1:0]  tw_in,
    input  logic [EXP_W-1:0] win_exp,
    input  logic [EXP_W-1:0] div_exp,
    input  logic             avg_mode,
    input  logic             auto_req,
    input  logic             auto_hold_en,
    input  logic             auto_recover_en,
    input  logic             hold_pin,
    input  logic             hold_ovr,
    input  logic             hold_manual,
    input  logic             ref_auto_b,
    input  logic             auto_sel_en,
    input  logic             ref_pin_b,
    input  logic             ref_ovr,
    input  logic             ref_manual_b,
    output logic [TW_W-1:0]  tw_out,
    output logic             holdover,
    output logic             avg_valid,
    output logic             ref_sel_b
);
    logic            strobe;
    logic            hold_q, hold_d;
    logic            entering, leaving, sample_en;
    logic [TW_W-1:0] avg_word;

    tw_strobe_gen #(.EXP_W(EXP_W)) strobe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_exp (div_exp),
        .strobe  (strobe)
    );

    tw_hold_ctrl ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .auto_req        (auto_req),
        .auto_hold_en    (auto_hold_en),
        .auto_recover_en (auto_recover_en),
        .hold_pin        (hold_pin),
        .hold_ovr        (hold_ovr),
        .hold_manual     (hold_manual),
        .ref_auto_b      (ref_auto_b),
        .auto_sel_en     (auto_sel_en),
        .ref_pin_b       (ref_pin_b),
        .ref_ovr         (ref_ovr),
        .ref_manual_b    (ref_manual_b),
        .hold_q          (hold_q),
        .hold_d          (hold_d),
        .ref_sel_b       (ref_sel_b)
    );

    // Transition decode and sampling gate: sample only while tracking.
    always_comb begin
        entering  = hold_d && !hold_q;
        leaving   = hold_q && !hold_d;
        sample_en = strobe && !hold_q && !hold_d;
    end

    tw_window_avg #(.TW_W(TW_W), .EXP_W(EXP_W)) avg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .restart   (leaving),
        .tw_in     (tw_in),
        .win_exp   (win_exp),
        .avg_word  (avg_word),
        .avg_valid (avg_valid)
    );

    // Output word: live on strobes, frozen choice on holdover entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tw_out <= '0;
        end else if (entering) begin
            if (avg_mode && avg_valid) tw_out <= avg_word;
        end else if (sample_en) begin
            tw_out <= tw_in;
        end
    end

    assign holdover = hold_q;

    AST_FROZEN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |=> (holdover -> $stable(tw_out)));  // R7
    AST_EXIT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(holdover) |-> !avg_valid);  // R8

endmodule

// File: tb/tw_holdover_avg_tb_top.sv
module tw_holdover_avg_tb_top;
    localparam int TW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tw_in = '0;
    logic [3:0]    win_exp = '0, div_exp = '0;
    logic avg_mode = 0, auto_req = 0, auto_hold_en = 0, auto_recover_en = 0;
    logic hold_pin = 0, hold_ovr = 0, hold_manual = 0;
    logic ref_auto_b = 0, auto_sel_en = 0, ref_pin_b = 0, ref_ovr = 0, ref_manual_b = 0;
    logic [TW-1:0] tw_out;
    logic holdover, avg_valid, ref_sel_b;

    always #2 clk = ~clk;

    tw_holdover_avg #(.TW_W(TW), .EXP_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .tw_in(tw_in), .win_exp(win_exp), .div_exp(div_exp),
        .avg_mode(avg_mode), .auto_req(auto_req), .auto_hold_en(auto_hold_en),
        .auto_recover_en(auto_recover_en), .hold_pin(hold_pin), .hold_ovr(hold_ovr),
        .hold_manual(hold_manual), .ref_auto_b(ref_auto_b), .auto_sel_en(auto_sel_en),
        .ref_pin_b(ref_pin_b), .ref_ovr(ref_ovr), .ref_manual_b(ref_manual_b),
        .tw_out(tw_out), .holdover(holdover), .avg_valid(avg_valid), .ref_sel_b(ref_sel_b)
    );

    int checks = 0, errors = 0, wd = 0;
    bit done = 0, cmp_on = 0;
    string cur_req = "R2";
    int unsigned seed = 32'h1234_5678;

    // Reference model state.
    longint m_cnt = 0;
    longint unsigned m_out = 0, m_avg = 0;
    bit m_hold = 0, m_valid = 0, m_ref = 0;
    longint unsigned win_q[$];

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_out = 0; m_avg = 0; m_hold = 0; m_valid = 0; m_ref = 0;
            win_q.delete();
        end else begin
            longint msk;
            bit strobe, nh;
            msk = (longint'(1) << div_exp) - 1;
            strobe = ((m_cnt & msk) == msk);
            if (hold_ovr)     nh = hold_manual;
            else if (hold_pin) nh = 1;
            else if (!m_hold) nh = auto_req && auto_hold_en;
            else              nh = !(!auto_req && auto_recover_en);
            if (nh && !m_hold) begin
                if (avg_mode && m_valid) m_out = m_avg;
            end else if (!nh && m_hold) begin
                win_q.delete();
                m_valid = 0;
            end else if (!m_hold && strobe) begin
                m_out = tw_in;
                win_q.push_back(tw_in);
                if (win_q.size() == (1 << win_exp)) begin
                    longint unsigned s;
                    s = 0;
                    foreach (win_q[i]) s += win_q[i];
                    m_avg = s >> win_exp;
                    m_valid = 1;
                    win_q.delete();
                end
            end
            m_hold = nh;
            m_ref = ref_ovr ? ref_manual_b : (auto_sel_en ? ref_auto_b : ref_pin_b);
            m_cnt++;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            chk({cur_req, " tw_out"}, tw_out, m_out);
            chk({cur_req, " holdover"}, holdover, m_hold);
            chk({cur_req, " avg_valid"}, avg_valid, m_valid);
            chk("R12 ref_sel_b", ref_sel_b, m_ref);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion below 100000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            tw_in = seed[31:8];
            @(negedge clk);
        end
    endtask

    initial begin
        logic [TW-1:0] last, frozen;
        step(3);
        // R1: reset state
        chk("R1 tw_out", tw_out, 0);
        chk("R1 holdover", holdover, 0);
        chk("R1 avg_valid", avg_valid, 0);
        chk("R1 ref_sel_b", ref_sel_b, 0);
        rst_n = 1; cmp_on = 1;

        // R2 / R3: live tracking, averaging windows
        cur_req = "R3"; div_exp = 2; win_exp = 2;
        run(40);
        chk("R3 window filled", avg_valid, 1);
        div_exp = 0; win_exp = 1;
        cur_req = "R2";
        run(12);
        div_exp = 1; win_exp = 3;
        run(40);
        chk("R3 valid again", avg_valid, 1);

        // R4: averaged entry, R7 frozen, R9 gated exit, R8 exit
        cur_req = "R4"; avg_mode = 1; auto_hold_en = 1; auto_req = 1;
        frozen = TW'(m_avg);
        step(1);
        chk("R4 averaged word", tw_out, frozen);
        chk("R4 holdover", holdover, 1);
        cur_req = "R7";
        run(20);
        chk("R7 output frozen", tw_out, frozen);
        cur_req = "R9"; auto_req = 0;
        run(10);
        chk("R9 no exit without recover enable", holdover, 1);
        cur_req = "R8"; auto_recover_en = 1;
        step(1);
        chk("R8 exited", holdover, 0);
        chk("R8 valid cleared", avg_valid, 0);
        run(9);

        // R5 / R11: last-word entry via pin
        cur_req = "R5"; avg_mode = 0; run(20);
        last = tw_out; hold_pin = 1;
        step(1);
        chk("R11 pin forces holdover", holdover, 1);
        chk("R5 last word held", tw_out, last);
        run(6);
        hold_pin = 0; step(1);
        chk("R9 recovery after pin release", holdover, 0);

        // R6 / R10: averaged mode before window valid, manual override
        cur_req = "R6"; win_exp = 4; div_exp = 2; avg_mode = 1;
        run(10);
        last = tw_out;
        hold_ovr = 1; hold_manual = 1;
        step(1);
        chk("R10 manual on", holdover, 1);
        chk("R6 fallback to last word", tw_out, last);
        cur_req = "R10"; hold_pin = 1; hold_manual = 0;
        step(1);
        chk("R10 manual off beats pin", holdover, 0);
        auto_req = 1; step(2);
        chk("R10 manual off beats auto", holdover, 0);
        hold_ovr = 0; hold_pin = 0; auto_req = 0;
        run(6);

        // R9: automatic entry gating
        cur_req = "R9"; auto_hold_en = 0; auto_req = 1; auto_recover_en = 0;
        run(10);
        chk("R9 no entry without enable", holdover, 0);
        auto_hold_en = 1; step(1);
        chk("R9 entry with enable", holdover, 1);
        auto_req = 0; auto_recover_en = 1; step(1);
        chk("R9 exit with recover", holdover, 0);

        // R12: reference selection precedence
        cur_req = "R12";
        ref_ovr = 1; ref_manual_b = 1; auto_sel_en = 1; ref_auto_b = 0; ref_pin_b = 0;
        step(1); chk("R12 manual B", ref_sel_b, 1);
        ref_ovr = 0; ref_pin_b = 1;
        step(1); chk("R12 auto A over pin", ref_sel_b, 0);
        auto_sel_en = 0;
        step(1); chk("R12 pin B", ref_sel_b, 1);
        ref_ovr = 1; ref_manual_b = 0;
        step(1); chk("R12 manual A over pin", ref_sel_b, 0);
        ref_ovr = 0; ref_pin_b = 0;

        // R13: largest window, all ones
        cur_req = "R13"; div_exp = 0; win_exp = 15; tw_in = '1;
        hold_ovr = 1; hold_manual = 1; step(1);
        hold_manual = 0; step(1);
        hold_ovr = 0;
        step(32768 + 2);
        chk("R13 window valid", avg_valid, 1);
        tw_in = '0; step(3);
        auto_req = 1; auto_hold_en = 1;
        step(1);
        chk("R13 averaged all ones", tw_out, 24'hFF_FFFF);
        step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule